// File: doc/BRIEF.md
# Vectored 64-Source Interrupt Controller

This block gathers 64 interrupt lines and sends each one to one of eight destinations: a normal interrupt line, a fast interrupt line, or one of six auxiliary lines. Every source has a control byte of its own. The byte holds an enable bit, a trigger mode (active-high level, rising edge, falling edge, or both edges) and a 3-bit destination code. Edge events are caught in a status bit. That bit stays set until software writes a one to it. Level sources show their live input in the same status words.

Two arbiters pick the source that wins: one for the normal line and one for the fast line. Software reads the winner's number from a register. With fixed priority the lowest source number wins. Each arbiter can be switched on its own to rotating priority: after a winner is read, the search starts at the next number and wraps at the top. When nothing is pending, the register reads the top source number (63). Software tells this idle value apart from a real source 63 by checking status bit 63.

The block sits on a simple word bus with byte strobes, and read data comes back one cycle after the read strobe. The address map ties the source count to 64.

Top module: `vec_intc`

## Requirements
- R1: After reset, every control byte reads 0, which means disabled, level mode and normal-line routing. All outputs are low and both status words read 0.
- R2: Control bytes for sources 4k to 4k+3 sit in the word at 0x40+4k, with source 4k+j in byte lane j. Within each byte, bit 3 is the enable, bits 6:5 are the trigger (00 level, 01 rising, 10 falling, 11 both edges) and bits 2:0 are the destination. Bits 7 and 4 read 0. Only lanes whose byte strobe is set are written.
- R3: For a level source, the status bit shows the live input. Writing to that status bit has no effect.
- R4: An edge source sets its status bit on the clock edge that sees the selected transition of its input.
- R5: A latched edge status bit stays set, even while the source is disabled. It is cleared only by writing a one to it, in word 0x80 for sources 0 to 31 or word 0x84 for sources 32 to 63, bit n%32, with that bit's byte strobe set.
- R6: Destination 0 drives irqOut, destination 1 drives fiqOut, and destination d from 2 to 7 drives auxOut[d-2]. Each output is high while any enabled source routed to it is pending.
- R7: A disabled source drives no output and is never reported as a winner.
- R8: A read at 0x00 returns in bits 5:0 the winning pending source routed to irqOut. In fixed mode this is the lowest number. When no such source is pending it returns 63.
- R9: A read at 0x04 returns the same result for sources routed to fiqOut.
- R10: The priority word at 0x20 (normal line) or 0x24 (fast line) holds the rotate enable in bit 6 and a start pointer in bits 5:0. In rotate mode the search begins at the pointer and wraps. Reading a real winner sets the pointer to winner+1, wrapping from 63 to 0, and the two arbiters do not affect each other.
- R11: busRdata carries the read result in the cycle after busRd and is 0 in every other cycle. Unmapped or unaligned addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Byte address |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busBe | input | 4 | Byte lane strobes for writes |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| srcIn | input | 64 | Interrupt source lines |
| irqOut | output | 1 | Normal interrupt line |
| fiqOut | output | 1 | Fast interrupt line |
| auxOut | output | 6 | Auxiliary destination lines |

## Verification
A one-hot sweep walks a single active level source across all 64 positions, with its destination code cycling through all eight values. This separates routing faults, output-decode faults and winner-number faults at every position. A thermometer sweep keeps all sources at or above k active, which tests lowest-number priority at every boundary, including a real source 63 against the idle result. A sparse pattern read repeatedly in rotate mode on each arbiter shows that the pointer advances and wraps and that the two arbiters stay apart. Edge cases run each trigger mode against both transitions, clears on the wrong lane, and latching while the source is disabled.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int BE_W   = DATA_W / 8;

  localparam logic [ADDR_W-1:0] A_WIN_IRQ  = 8'h00;
  localparam logic [ADDR_W-1:0] A_WIN_FIQ  = 8'h04;
  localparam logic [ADDR_W-1:0] A_PRIO_IRQ = 8'h20;
  localparam logic [ADDR_W-1:0] A_PRIO_FIQ = 8'h24;

  typedef enum logic [2:0] {
    RD_NONE, RD_WIN_IRQ, RD_WIN_FIQ, RD_PRIO_IRQ, RD_PRIO_FIQ, RD_CTL, RD_STAT
  } rdSel_e;

  typedef struct packed {
    rdSel_e            rdSel;
    logic              winRdIrq;
    logic              winRdFiq;
    logic              prioWrIrq;
    logic              prioWrFiq;
    logic              ctlWr;
    logic              statWr;
    logic [3:0]        wordIdx;
    logic [BE_W-1:0]   be;
    logic [DATA_W-1:0] wdata;
  } strobe_t;
endpackage

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [BE_W-1:0]   busBe,
  input  logic [DATA_W-1:0] busWdata,
  output strobe_t           strb
);
  logic aligned, inCtl, inStat;

  always_comb begin
    aligned = (busAddr[1:0] == 2'b00);
    inCtl   = aligned && (busAddr[7:6] == 2'b01);
    inStat  = aligned && (busAddr[7:3] == 5'b10000);

    strb           = '0;
    strb.wordIdx   = busAddr[5:2];
    strb.be        = busBe;
    strb.wdata     = busWdata;
    strb.ctlWr     = busWr && inCtl;
    strb.statWr    = busWr && inStat;
    strb.prioWrIrq = busWr && (busAddr == A_PRIO_IRQ);
    strb.prioWrFiq = busWr && (busAddr == A_PRIO_FIQ);
    strb.winRdIrq  = busRd && (busAddr == A_WIN_IRQ);
    strb.winRdFiq  = busRd && (busAddr == A_WIN_FIQ);
    strb.rdSel     = RD_NONE;
    if (busRd) begin
      if (inCtl)       strb.rdSel = RD_CTL;
      else if (inStat) strb.rdSel = RD_STAT;
      else begin
        case (busAddr)
          A_WIN_IRQ:  strb.rdSel = RD_WIN_IRQ;
          A_WIN_FIQ:  strb.rdSel = RD_WIN_FIQ;
          A_PRIO_IRQ: strb.rdSel = RD_PRIO_IRQ;
          A_PRIO_FIQ: strb.rdSel = RD_PRIO_FIQ;
          default:    strb.rdSel = RD_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/intc_arb.sv
module intc_arb #(
  parameter int NUM_SRC = 64,
  localparam int IDW = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] cand,
  input  logic               prioWr,
  input  logic               prioBe,
  input  logic [6:0]         prioWdata,
  input  logic               winRd,
  output logic [IDW-1:0]     win,
  output logic               rotOn,
  output logic [IDW-1:0]     ptr
);
  localparam logic [IDW-1:0] IDLE = IDW'(NUM_SRC - 1);

  logic [NUM_SRC-1:0] aboveMask, masked;

  function automatic logic [IDW-1:0] lowestSet(input logic [NUM_SRC-1:0] v);
    logic [IDW-1:0] r;
    r = IDLE;
    for (int i = NUM_SRC - 1; i >= 0; i--)
      if (v[i]) r = IDW'(i);
    return r;
  endfunction

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_mask
    assign aboveMask[i] = (IDW'(i) >= ptr);
  end

  assign masked = cand & aboveMask;
  assign win    = (rotOn && (|masked)) ? lowestSet(masked) : lowestSet(cand);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rotOn <= 1'b0;
      ptr   <= '0;
    end else if (prioWr) begin
      if (prioBe) begin
        rotOn <= prioWdata[6];
        ptr   <= prioWdata[IDW-1:0];
      end
    end else if (winRd && rotOn && (|cand)) begin
      ptr <= (win == IDLE) ? '0 : win + 1'b1;
    end
  end
endmodule

// File: rtl/intc_dp.sv
module intc_dp
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int NUM_AUX = 6,
  localparam int IDW = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  input  logic [NUM_SRC-1:0] srcIn,
  output logic               irqOut,
  output logic               fiqOut,
  output logic [NUM_AUX-1:0] auxOut,
  output logic [DATA_W-1:0]  rdData,
  output logic [NUM_SRC-1:0] latchVec,
  output logic [NUM_SRC-1:0] irqCand,
  output logic [NUM_SRC-1:0] fiqCand,
  output logic [IDW-1:0]     irqWin,
  output logic [IDW-1:0]     fiqWin,
  output logic               rotIrq,
  output logic [IDW-1:0]     ptrIrq
);
  logic [NUM_SRC-1:0]              prevIn, pending;
  logic [63:0]                     pendPad;
  logic [63:0][7:0]                ctlPad;
  logic [NUM_AUX-1:0][NUM_SRC-1:0] auxCand;
  logic                            rotFiq;
  logic [IDW-1:0]                  ptrFiq;
  logic [DATA_W-1:0]               rdNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevIn <= '0;
    else       prevIn <= srcIn;
  end

  for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
    localparam int WRD = n / BE_W;
    localparam int LN  = n % BE_W;
    localparam int SW  = n / DATA_W;
    localparam int SB  = n % DATA_W;
    logic       enR, edgeHit, clrHit, live;
    logic [1:0] trigR;
    logic [2:0] destR;
    logic       latchR;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        enR   <= 1'b0;
        trigR <= 2'b00;
        destR <= 3'd0;
      end else if (strb.ctlWr && (strb.wordIdx == 4'(WRD)) && strb.be[LN]) begin
        enR   <= strb.wdata[8*LN+3];
        trigR <= strb.wdata[8*LN+5 +: 2];
        destR <= strb.wdata[8*LN +: 3];
      end
    end

    assign edgeHit = (trigR[0] & srcIn[n] & ~prevIn[n]) |
                     (trigR[1] & ~srcIn[n] & prevIn[n]);
    assign clrHit  = strb.statWr && (strb.wordIdx[0] == 1'(SW)) &&
                     strb.be[SB/8] && strb.wdata[SB];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           latchR <= 1'b0;
      else if (~|trigR)    latchR <= 1'b0;
      else if (edgeHit)    latchR <= 1'b1;
      else if (clrHit)     latchR <= 1'b0;
    end

    assign latchVec[n] = latchR;
    assign pending[n]  = (|trigR) ? latchR : srcIn[n];
    assign live        = pending[n] & enR;
    assign irqCand[n]  = live && (destR == 3'd0);
    assign fiqCand[n]  = live && (destR == 3'd1);
    assign ctlPad[n]   = {1'b0, trigR, 1'b0, enR, destR};
    for (genvar a = 0; a < NUM_AUX; a++) begin : g_aux
      assign auxCand[a][n] = live && (destR == 3'(a + 2));
    end
  end

  for (genvar n = NUM_SRC; n < 64; n++) begin : g_pad
    assign ctlPad[n] = 8'h00;
  end

  assign pendPad = 64'(pending);

  for (genvar a = 0; a < NUM_AUX; a++) begin : g_auxOut
    assign auxOut[a] = |auxCand[a];
  end
  assign irqOut = |irqCand;
  assign fiqOut = |fiqCand;

  intc_arb #(.NUM_SRC(NUM_SRC)) u_arbIrq (
    .clk(clk), .rstN(rstN), .cand(irqCand),
    .prioWr(strb.prioWrIrq), .prioBe(strb.be[0]), .prioWdata(strb.wdata[6:0]),
    .winRd(strb.winRdIrq), .win(irqWin), .rotOn(rotIrq), .ptr(ptrIrq)
  );

  intc_arb #(.NUM_SRC(NUM_SRC)) u_arbFiq (
    .clk(clk), .rstN(rstN), .cand(fiqCand),
    .prioWr(strb.prioWrFiq), .prioBe(strb.be[0]), .prioWdata(strb.wdata[6:0]),
    .winRd(strb.winRdFiq), .win(fiqWin), .rotOn(rotFiq), .ptr(ptrFiq)
  );

  always_comb begin
    case (strb.rdSel)
      RD_WIN_IRQ:  rdNext = DATA_W'(irqWin);
      RD_WIN_FIQ:  rdNext = DATA_W'(fiqWin);
      RD_PRIO_IRQ: rdNext = DATA_W'({rotIrq, 6'(ptrIrq)});
      RD_PRIO_FIQ: rdNext = DATA_W'({rotFiq, 6'(ptrFiq)});
      RD_CTL:      rdNext = ctlPad[{strb.wordIdx, 2'b00} +: 4];
      RD_STAT:     rdNext = strb.wordIdx[0] ? pendPad[63:32] : pendPad[31:0];
      default:     rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else       rdData <= rdNext;
  end
endmodule

// File: rtl/vec_intc.sv
module vec_intc
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int NUM_AUX = 6,
  localparam int IDW = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWr,
  input  logic               busRd,
  input  logic [BE_W-1:0]    busBe,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  input  logic [NUM_SRC-1:0] srcIn,
  output logic               irqOut,
  output logic               fiqOut,
  output logic [NUM_AUX-1:0] auxOut
);
  strobe_t            strb;
  logic [NUM_SRC-1:0] latchVec, irqCand, fiqCand;
  logic [IDW-1:0]     irqWin, fiqWin, ptrIrq;
  logic               rotIrq;

  intc_ctrl u_ctrl (
    .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busBe(busBe), .busWdata(busWdata), .strb(strb)
  );

  intc_dp #(.NUM_SRC(NUM_SRC), .NUM_AUX(NUM_AUX)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .srcIn(srcIn),
    .irqOut(irqOut), .fiqOut(fiqOut), .auxOut(auxOut), .rdData(busRdata),
    .latchVec(latchVec), .irqCand(irqCand), .fiqCand(fiqCand),
    .irqWin(irqWin), .fiqWin(fiqWin), .rotIrq(rotIrq), .ptrIrq(ptrIrq)
  );
endmodule

// File: rtl/vec_intc_chk.sv
module vec_intc_chk #(
  parameter int NUM_SRC = 64,
  localparam int IDW = $clog2(NUM_SRC)
) (
  input logic               clk,
  input logic               rstN,
  input logic [7:0]         busAddr,
  input logic               busWr,
  input logic               busRd,
  input logic [31:0]        busRdata,
  input logic               irqOut,
  input logic               fiqOut,
  input logic [NUM_SRC-1:0] latchVec,
  input logic [NUM_SRC-1:0] irqCand,
  input logic [IDW-1:0]     irqWin,
  input logic [IDW-1:0]     fiqWin,
  input logic               rotIrq,
  input logic [IDW-1:0]     ptrIrq
);
  localparam logic [IDW-1:0] IDLE = IDW'(NUM_SRC - 1);

  // R5
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busWr |=> ((latchVec & $past(latchVec)) == $past(latchVec)));

  // R8
  irq_idle_win_chk: assert property (@(posedge clk) disable iff (!rstN)
    !irqOut |-> (irqWin == IDLE));

  // R9
  fiq_idle_win_chk: assert property (@(posedge clk) disable iff (!rstN)
    !fiqOut |-> (fiqWin == IDLE));

  // R6
  irq_win_real_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> irqCand[irqWin]);

  // R11
  rd_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busRd |=> (busRdata == 32'h0));

  // R10
  rot_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && !busWr && (busAddr == 8'h00) && rotIrq && irqOut) |=>
      (ptrIrq == (($past(irqWin) == IDLE) ? '0 : $past(irqWin) + 1'b1)));
endmodule

bind vec_intc vec_intc_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
  .busRdata(busRdata), .irqOut(irqOut), .fiqOut(fiqOut), .latchVec(latchVec),
  .irqCand(irqCand), .irqWin(irqWin), .fiqWin(fiqWin), .rotIrq(rotIrq),
  .ptrIrq(ptrIrq)
);

// File: tb/sim_vec_intc.sv
module sim_vec_intc;
  logic        clk = 1'b0;
  logic        rstN;
  logic [7:0]  busAddr;
  logic        busWr, busRd;
  logic [3:0]  busBe;
  logic [31:0] busWdata, busRdata;
  logic [63:0] srcIn;
  logic        irqOut, fiqOut;
  logic [5:0]  auxOut;
  int vecs = 0;
  int errs = 0;

  always #5 clk = ~clk;

  vec_intc u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busBe(busBe), .busWdata(busWdata), .busRdata(busRdata), .srcIn(srcIn),
    .irqOut(irqOut), .fiqOut(fiqOut), .auxOut(auxOut)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    busAddr = a; busWdata = d; busBe = be; busWr = 1'b1;
    tick;
    busWr = 1'b0; busBe = 4'h0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    busAddr = a; busRd = 1'b1;
    tick;
    busRd = 1'b0;
    d = busRdata;
  endtask

  task automatic setByte(input int n, input logic [7:0] b);
    wr(8'(8'h40 + 4 * (n / 4)), 32'(b) << (8 * (n % 4)), 4'(1 << (n % 4)));
  endtask

  task automatic fillCtl(input logic [31:0] d);
    for (int w = 0; w < 16; w++) wr(8'(8'h40 + 4 * w), d, 4'hF);
  endtask

  function automatic int pick(input logic [63:0] c, input bit rot, input int p);
    if (rot) for (int i = p; i < 64; i++) if (c[i]) return i;
    for (int i = 0; i < 64; i++) if (c[i]) return i;
    return 63;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    logic [31:0] r, pat;
    int ptr, e;
    rstN = 1'b0; busAddr = '0; busWr = 1'b0; busRd = 1'b0; busBe = '0;
    busWdata = '0; srcIn = '0;
    repeat (3) tick;
    rstN = 1'b1;
    tick;

    // R1 reset state
    check("R1 outputs", {irqOut, fiqOut, auxOut}, 0);
    for (int w = 0; w < 16; w++) begin rd(8'(8'h40 + 4 * w), r); check("R1 ctl", r, 0); end
    rd(8'h80, r); check("R1 stat0", r, 0);
    rd(8'h84, r); check("R1 stat1", r, 0);
    rd(8'h00, r); check("R8 idle", r, 63);

    // R2 readback with masking and byte lanes
    for (int w = 0; w < 16; w++) begin
      pat = 32'h9E3779B9 * (w + 1);
      wr(8'(8'h40 + 4 * w), pat, 4'hF);
      rd(8'(8'h40 + 4 * w), r);
      check("R2 readback", r, pat & 32'h6F6F6F6F);
    end
    pat = (32'h9E3779B9 * 2) & 32'h6F6F6F6F;
    wr(8'h44, 32'hFFFFFFFF, 4'b0100);
    rd(8'h44, r); check("R2 lane", r, (pat & 32'hFF00FFFF) | 32'h006F0000);
    fillCtl(32'h0);

    // R6 R8 R9 one-hot routing sweep
    for (int n = 0; n < 64; n++) begin
      int d;
      d = n % 8;
      setByte(n, 8'(8'h08 | d));
      srcIn = 64'd1 << n;
      #1;
      check("R6 irq", irqOut, d == 0);
      check("R6 fiq", fiqOut, d == 1);
      check("R6 aux", auxOut, (d >= 2) ? (64'd1 << (d - 2)) : 0);
      rd(8'h00, r); check("R8 win", r, (d == 0) ? n : 63);
      rd(8'h04, r); check("R9 win", r, (d == 1) ? n : 63);
      rd(8'(8'h80 + 4 * (n / 32)), r); check("R3 live", r, 32'd1 << (n % 32));
      srcIn = '0;
      setByte(n, 8'h00);
    end

    // R7 disabled sources
    srcIn = '1;
    #1;
    check("R7 outputs", {irqOut, fiqOut, auxOut}, 0);
    rd(8'h00, r); check("R7 win", r, 63);
    rd(8'h80, r); check("R3 live all", r, 32'hFFFFFFFF);

    // R8 thermometer sweep, fixed priority
    fillCtl(32'h08080808);
    for (int k = 0; k < 64; k++) begin
      srcIn = ~64'd0 << k;
      rd(8'h00, r); check("R8 fixed", r, k);
    end
    srcIn = '0;
    rd(8'h00, r); check("R8 empty", r, 63);
    rd(8'h84, r); check("R8 empty stat", r, 0);
    srcIn = 64'd1 << 63;
    rd(8'h00, r); check("R8 real63", r, 63);
    rd(8'h84, r); check("R8 real63 stat", r, 32'h80000000);

    // R3 level status write ignored
    srcIn = 64'h8;
    wr(8'h80, 32'hFFFFFFFF, 4'hF);
    rd(8'h80, r); check("R3 w1c ignored", r, 32'h8);
    check("R3 irq kept", irqOut, 1);

    // R10 rotating on the normal line
    srcIn = (64'd1 << 5) | (64'd1 << 20) | (64'd1 << 40) | (64'd1 << 63);
    wr(8'h20, 32'h40, 4'h1);
    ptr = 0;
    for (int i = 0; i < 10; i++) begin
      e = pick(srcIn, 1'b1, ptr);
      rd(8'h00, r); check("R10 rotate", r, e);
      ptr = (e == 63) ? 0 : e + 1;
    end
    rd(8'h20, r); check("R10 ptr", r, 32'h40 | ptr);
    wr(8'h20, 32'h40 | 30, 4'h1);
    rd(8'h00, r); check("R10 ptr set", r, 40);
    wr(8'h20, 32'h0, 4'h1);
    rd(8'h00, r); check("R10 fixed back", r, 5);
    rd(8'h00, r); check("R10 fixed stays", r, 5);

    // R9 R10 rotating on the fast line
    fillCtl(32'h09090909);
    srcIn = (64'd1 << 7) | (64'd1 << 50);
    wr(8'h24, 32'h40 | 8, 4'h1);
    rd(8'h04, r); check("R9 rot a", r, 50);
    rd(8'h04, r); check("R9 rot b", r, 7);
    rd(8'h04, r); check("R9 rot c", r, 50);
    check("R6 fiq only", {irqOut, fiqOut}, 2'b01);
    rd(8'h00, r); check("R8 none irq", r, 63);
    rd(8'h20, r); check("R10 apart", r, 0);

    // R4 R5 edge behaviour
    srcIn = '0;
    fillCtl(32'h0);
    setByte(10, 8'h28);
    srcIn[10] = 1'b1; tick;
    check("R4 rise", irqOut, 1);
    rd(8'h80, r); check("R4 stat", r, 32'h400);
    srcIn[10] = 1'b0; tick;
    check("R5 held", irqOut, 1);
    wr(8'h80, 32'h0, 4'hF);
    check("R5 zero write", irqOut, 1);
    wr(8'h80, 32'h400, 4'b0001);
    check("R5 wrong lane", irqOut, 1);
    wr(8'h80, 32'h400, 4'b0010);
    check("R5 cleared", irqOut, 0);

    setByte(10, 8'h48);
    srcIn[10] = 1'b1; tick;
    check("R4 fall no rise", irqOut, 0);
    srcIn[10] = 1'b0; tick;
    check("R4 fall", irqOut, 1);
    wr(8'h80, 32'h400, 4'hF);

    setByte(10, 8'h68);
    srcIn[10] = 1'b1; tick;
    check("R4 both rise", irqOut, 1);
    wr(8'h80, 32'h400, 4'hF);
    check("R4 both clr", irqOut, 0);
    srcIn[10] = 1'b0; tick;
    check("R4 both fall", irqOut, 1);
    wr(8'h80, 32'h400, 4'hF);

    setByte(10, 8'h20);
    srcIn[10] = 1'b1; tick;
    check("R7 edge disabled", irqOut, 0);
    rd(8'h80, r); check("R5 latched disabled", r, 32'h400);
    setByte(10, 8'h28);
    check("R5 persists", irqOut, 1);
    wr(8'h80, 32'h400, 4'hF);
    srcIn[10] = 1'b0;

    setByte(45, 8'h2D);
    srcIn[45] = 1'b1; tick;
    check("R6 aux edge", auxOut, 6'h08);
    wr(8'h84, 32'h2000, 4'b0010);
    check("R5 hi clear", auxOut, 0);

    // R11 unmapped reads
    rd(8'h10, r); check("R11 hole", r, 0);
    rd(8'h81, r); check("R11 unaligned", r, 0);
    tick;
    check("R11 quiet", busRdata, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule